// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frame bytes into memory buffers that software hands out through a ring of 8-byte descriptors. For each frame it reads the current descriptor over a single request/acknowledge memory port. It checks that the receiver owns that descriptor and then writes the frame bytes, one at a time, into the buffer the descriptor points to. A long frame is spread over as many descriptors as it needs. When a buffer is finished, the engine writes back the status and length word, which also returns ownership to software. It then raises an event pulse and moves on to the next descriptor in the ring.

Each descriptor has three fields. The status/control word is a big-endian 16-bit half-word at offset 0, and the length is a big-endian 16-bit half-word at offset 2. Together they form the 32-bit word read and written at offset 0. The buffer pointer is the 32-bit word at offset 4. Status bits are named by position from the most significant bit down:

| Bit (15 = MSB) | Meaning |
|---|---|
| 15 | owned by engine |
| 14 | reserved |
| 13 | wrap |
| 12 | event request |
| 11 | last of frame |
| 10 | first of frame |
| 9 | CAM miss |
| 8 | promiscuous miss |
| 7 | broadcast |
| 6 | multicast |
| 5..0 | error flags, the `rx_err` bits in order (too long, non-aligned, short, CRC, overrun, collision) |

The address filter, the CRC checker and the framing logic live outside this block. They deliver their results as flags that are sampled with the end-of-frame byte.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the engine issues no memory request, raises no event, and starts at the descriptor at `ring_base`.
- R2: A buffer is used only if its descriptor's owned bit (bit 15) reads 1. Every write-back stores 0 there, stores 0 in bit 14, and keeps the wrap (bit 13) and event request (bit 12) bits as read.
- R3: Frame bytes are stored in arrival order at consecutive byte addresses starting at the descriptor's buffer pointer. Memory is big-endian: the byte at address A goes on lane `mem_be[3 - A%4]`, which is `mem_wdata` bits [31-8*(A%4) -: 8].
- R4: A buffer that does not end its frame is filled with exactly `buf_size` bytes. Its length field is written as `buf_size`, bit 11 is 0, and bits 9..0 are 0.
- R5: The first buffer of a frame has bit 10 set and all later buffers have it clear. The buffer holding the frame's final byte has bit 11 set and a length equal to the frame's total byte count. Its bits 8, 7, 6 and 5..0 carry `rx_prom_miss`, `rx_bc`, `rx_mc` and `rx_err` as they stood with the end-of-frame byte.
- R6: After using a descriptor whose wrap bit is 1, the next descriptor fetched is the one at `ring_base`. Otherwise the next descriptor is the current one plus 8.
- R7: On write-back of a descriptor with the event request bit set, `ev_rxf` pulses for one cycle if bit 11 was written 1, and `ev_rxb` pulses otherwise. With the event request bit clear, neither pulses.
- R8: Bit 9 is written with `rx_cam_miss` only in a buffer with bit 11 set while `cam_en` is 1. In every other case it is written 0.
- R9: If the fetched descriptor's owned bit is 0, `ev_busy` pulses and the rest of the current frame is consumed without any memory write. That descriptor is left untouched and is fetched again when the next frame starts. This holds both at frame start and in the middle of a frame.
- R10: If the descriptor at `ring_base` itself has its wrap bit set (a one-entry ring), `ev_cfg` pulses and the frame is consumed without any memory write.
- R11: Bytes that arrive without a frame start while the engine is idle are consumed and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor |
| buf_size | input | 16 | Bytes per receive buffer |
| cam_en | input | 1 | Enables writing the CAM result bit |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Receive byte taken on this edge |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 6 | Frame error flags, valid with `rx_eof` |
| rx_bc | input | 1 | Broadcast destination, valid with `rx_eof` |
| rx_mc | input | 1 | Multicast destination, valid with `rx_eof` |
| rx_cam_miss | input | 1 | CAM lookup missed, valid with `rx_eof` |
| rx_prom_miss | input | 1 | Accepted only by promiscuous mode, valid with `rx_eof` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| ev_rxb | output | 1 | Buffer-done event pulse |
| ev_rxf | output | 1 | Frame-done event pulse |
| ev_busy | output | 1 | No owned descriptor available |
| ev_cfg | output | 1 | One-entry ring detected |

## Verification
A corrupted ring address would show up at once in the descriptor contents: the next write-back lands in the wrong slot, so a status check fails one buffer later. A wrong byte counter shows up in the buffer bytes, and in a length field that disagrees with the frame length as soon as that buffer closes. A wrong first/last flag or a wrong busy decision shows up in the written status word and in the event pulse counts for that same frame. The bench re-reads the descriptors and untouched buffers after every frame, so none of these faults can hide beyond the frame that caused them.

// File: rtl/rx_desc_ring_pkg.sv
package rx_desc_ring_pkg;
    localparam int LEN_W  = 16;
    localparam int DESC_B = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STS,
        ST_RD_PTR,
        ST_DATA,
        ST_WR_BYTE,
        ST_WR_STS,
        ST_DROP
    } eng_st_t;
endpackage

// File: rtl/rx_ring_step.sv
module rx_ring_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          wrap,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP = AW'(rx_desc_ring_pkg::DESC_B);

    always_comb begin
        nxt = wrap ? base : cur + STEP;
    end
endmodule

// File: rtl/rx_stat_pack.sv
module rx_stat_pack (
    input  logic        wrap,
    input  logic        ien,
    input  logic        first,
    input  logic        last,
    input  logic        cam_en,
    input  logic        cam_miss,
    input  logic        prom_miss,
    input  logic        bc,
    input  logic        mc,
    input  logic [5:0]  err,
    output logic [15:0] word
);
    always_comb begin
        word = {1'b0, 1'b0, wrap, ien, last, first,
                last & cam_en & cam_miss,
                last & prom_miss,
                last & bc,
                last & mc,
                last ? err : 6'd0};
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rx_desc_ring_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [LEN_W-1:0] buf_size,
    input  logic          cam_en,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic [5:0]    rx_err,
    input  logic          rx_bc,
    input  logic          rx_mc,
    input  logic          rx_cam_miss,
    input  logic          rx_prom_miss,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          ev_rxb,
    output logic          ev_rxf,
    output logic          ev_busy,
    output logic          ev_cfg
);
    localparam logic [AW-1:0] PTR_OFS = AW'(4);

    typedef struct packed {
        eng_st_t          st;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    wadr;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] tot;
        logic [LEN_W-1:0] len;
        logic [15:0]      sts;
        logic [7:0]       dbyte;
        logic             wrap;
        logic             ien;
        logic             first;
        logic             last;
        logic             done;
        logic             ev_rxb;
        logic             ev_rxf;
        logic             ev_busy;
        logic             ev_cfg;
    } eng_t;

    eng_t q, d;

    logic [AW-1:0] nxt_desc;
    logic [15:0]   sts_word;

    rx_ring_step #(.AW(AW)) step_i (
        .cur  (q.cur),
        .base (ring_base),
        .wrap (q.wrap),
        .nxt  (nxt_desc)
    );

    rx_stat_pack pack_i (
        .wrap      (q.wrap),
        .ien       (q.ien),
        .first     (q.first),
        .last      (rx_eof),
        .cam_en    (cam_en),
        .cam_miss  (rx_cam_miss),
        .prom_miss (rx_prom_miss),
        .bc        (rx_bc),
        .mc        (rx_mc),
        .err       (rx_err),
        .word      (sts_word)
    );

    always_comb begin
        d         = q;
        d.ev_rxb  = 1'b0;
        d.ev_rxf  = 1'b0;
        d.ev_busy = 1'b0;
        d.ev_cfg  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 4'h0;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                rx_ready = rx_valid & ~rx_sof;
                if (rx_valid && rx_sof) begin
                    d.st    = ST_RD_STS;
                    d.first = 1'b1;
                    d.tot   = '0;
                end
            end
            ST_RD_STS: begin
                mem_req  = 1'b1;
                mem_addr = q.cur;
                if (mem_ack) begin
                    if (!mem_rdata[31]) begin
                        d.ev_busy = 1'b1;
                        d.st      = ST_DROP;
                    end else if (mem_rdata[29] && (q.cur == ring_base)) begin
                        d.ev_cfg = 1'b1;
                        d.st     = ST_DROP;
                    end else begin
                        d.wrap = mem_rdata[29];
                        d.ien  = mem_rdata[28];
                        d.st   = ST_RD_PTR;
                    end
                end
            end
            ST_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + PTR_OFS;
                if (mem_ack) begin
                    d.ptr = mem_rdata;
                    d.cnt = '0;
                    d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.wadr  = q.ptr + AW'(q.cnt);
                    d.dbyte = rx_data;
                    d.cnt   = q.cnt + 1'b1;
                    d.tot   = q.tot + 1'b1;
                    d.last  = rx_eof;
                    d.done  = rx_eof || ((q.cnt + 1'b1) == buf_size);
                    d.len   = rx_eof ? q.tot + 1'b1 : buf_size;
                    d.sts   = sts_word;
                    d.st    = ST_WR_BYTE;
                end
            end
            ST_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.wadr[AW-1:2], 2'b00};
                mem_be    = 4'b1000 >> q.wadr[1:0];
                mem_wdata = {4{q.dbyte}};
                if (mem_ack) begin
                    d.st = q.done ? ST_WR_STS : ST_DATA;
                end
            end
            ST_WR_STS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.cur;
                mem_be    = 4'hF;
                mem_wdata = {q.sts, q.len};
                if (mem_ack) begin
                    d.ev_rxf = q.ien & q.last;
                    d.ev_rxb = q.ien & ~q.last;
                    d.cur    = nxt_desc;
                    d.first  = 1'b0;
                    d.st     = q.last ? ST_IDLE : ST_RD_STS;
                end
            end
            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_eof) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cur <= ring_base;
        end else begin
            q <= d;
        end
    end

    assign ev_rxb  = q.ev_rxb;
    assign ev_rxf  = q.ev_rxf;
    assign ev_busy = q.ev_busy;
    assign ev_cfg  = q.ev_cfg;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_no_rx_during_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rx_ready);

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && buf_size != '0) |-> (q.cnt < buf_size));

    p_wrap_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WR_STS && mem_ack && q.wrap) |=> (q.cur == $past(ring_base)));

    p_event_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rxf && ev_rxb));

    p_busy_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_busy) |-> ($stable(q.cur) && !mem_req));
endmodule

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic [15:0] buf_size = 16'd8;
    logic        cam_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [5:0]  rx_err = 6'h0;
    logic        rx_bc = 1'b0;
    logic        rx_mc = 1'b0;
    logic        rx_cam_miss = 1'b0;
    logic        rx_prom_miss = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        ev_rxb, ev_rxf, ev_busy, ev_cfg;

    logic [7:0] mem [0:255];
    int n_total = 0;
    int n_bad = 0;
    int n_rxb = 0, n_rxf = 0, n_busy = 0, n_cfg = 0;
    int ring_idx = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rx_desc_ring dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .buf_size(buf_size),
        .cam_en(cam_en), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .rx_bc(rx_bc), .rx_mc(rx_mc), .rx_cam_miss(rx_cam_miss),
        .rx_prom_miss(rx_prom_miss), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ev_rxb(ev_rxb),
        .ev_rxf(ev_rxf), .ev_busy(ev_busy), .ev_cfg(ev_cfg)
    );

    // memory responder: one-cycle acknowledge, big-endian byte lanes
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= {mem[{mem_addr[7:2], 2'd0}], mem[{mem_addr[7:2], 2'd1}],
                          mem[{mem_addr[7:2], 2'd2}], mem[{mem_addr[7:2], 2'd3}]};
            if (mem_we) begin
                if (mem_be[3]) mem[{mem_addr[7:2], 2'd0}] = mem_wdata[31:24];
                if (mem_be[2]) mem[{mem_addr[7:2], 2'd1}] = mem_wdata[23:16];
                if (mem_be[1]) mem[{mem_addr[7:2], 2'd2}] = mem_wdata[15:8];
                if (mem_be[0]) mem[{mem_addr[7:2], 2'd3}] = mem_wdata[7:0];
            end
        end
    end

    always @(negedge clk) begin
        if (ev_rxb)  n_rxb++;
        if (ev_rxf)  n_rxf++;
        if (ev_busy) n_busy++;
        if (ev_cfg)  n_cfg++;
    end

    // {len[19:12], cam_en, cam_miss, prom_miss, bc, mc, ien, err[5:0]}
    localparam logic [19:0] VEC [0:5] = '{
        {8'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000000},
        {8'd8,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'b000000},
        {8'd13, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'b000000},
        {8'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000100},
        {8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'b000010},
        {8'd1,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'b100001}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input int a);
        return {mem[a & 255], mem[(a + 1) & 255]};
    endfunction

    task automatic arm(input int idx, input bit own, input bit ien);
        mem[idx*8]   = {own, 1'b0, (idx == 3), ien, 4'h0};
        mem[idx*8+1] = 8'h00;
        mem[idx*8+2] = 8'h00;
        mem[idx*8+3] = 8'h00;
        mem[idx*8+4] = 8'h00;
        mem[idx*8+5] = 8'h00;
        mem[idx*8+6] = 8'h00;
        mem[idx*8+7] = 8'(8'h40 + idx*16);
    endtask

    task automatic send(input int len, input int seed);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + j);
            rx_sof   = (j == 0);
            rx_eof   = (j == len - 1);
            #1;
            while (!rx_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic do_reset(input logic [31:0] base);
        @(negedge clk);
        rst_n = 1'b0;
        ring_base = base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(!mem_req && !rx_ready, "R1 idle after reset", {mem_req, rx_ready}, 0);
        check(!(ev_rxb | ev_rxf | ev_busy | ev_cfg), "R1 no events", 1, 0);

        // R11 stray bytes without frame start
        for (int k = 0; k < 4; k++) arm(k, 1'b1, 1'b1);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77; rx_sof = 1'b0; rx_eof = 1'b1;
        #1;
        check(rx_ready == 1'b1, "R11 stray byte taken", rx_ready, 1);
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (10) @(negedge clk);
        check(rd16(0) == 16'h9000, "R11 descriptor untouched", rd16(0), 16'h9000);

        // vector walk
        for (int v = 0; v < 6; v++) begin
            automatic int len   = VEC[v][19:12];
            automatic bit ien   = VEC[v][6];
            automatic int nb    = (len + 7) / 8;
            automatic int seed  = 16 + v * 37;
            automatic int rxb0  = n_rxb;
            automatic int rxf0  = n_rxf;
            for (int k = 0; k < 4; k++) arm(k, 1'b1, ien);
            cam_en = VEC[v][11]; rx_cam_miss = VEC[v][10]; rx_prom_miss = VEC[v][9];
            rx_bc = VEC[v][8]; rx_mc = VEC[v][7]; rx_err = VEC[v][5:0];
            send(len, seed);
            for (int b = 0; b < nb; b++) begin
                automatic int di = (ring_idx + b) % 4;
                automatic bit lst = (b == nb - 1);
                automatic int cnt = lst ? len - 8*b : 8;
                automatic logic [15:0] es = {2'b00, (di == 3), ien, lst, (b == 0),
                    lst & VEC[v][11] & VEC[v][10], lst & VEC[v][9],
                    lst & VEC[v][8], lst & VEC[v][7], lst ? VEC[v][5:0] : 6'd0};
                automatic int miss = 0;
                check(rd16(di*8) == es, "R2 R4 R5 R6 R8 status", rd16(di*8), es);
                check(rd16(di*8+2) == 16'(lst ? len : 8), "R4 R5 length",
                      rd16(di*8+2), lst ? len : 8);
                for (int j = 0; j < cnt; j++)
                    if (mem[8'h40 + di*16 + j] != 8'(seed + 8*b + j)) miss++;
                check(miss == 0, "R3 buffer bytes", miss, 0);
            end
            ring_idx = (ring_idx + nb) % 4;
            check(n_rxf - rxf0 == (ien ? 1 : 0), "R7 frame events", n_rxf - rxf0, ien ? 1 : 0);
            check(n_rxb - rxb0 == (ien ? nb - 1 : 0), "R7 buffer events",
                  n_rxb - rxb0, ien ? nb - 1 : 0);
        end
        cam_en = 1'b0; rx_cam_miss = 1'b0; rx_prom_miss = 1'b0;
        rx_bc = 1'b0; rx_mc = 1'b0; rx_err = 6'h0;

        // R9 mid-frame busy: second descriptor not owned
        begin
            automatic int d0 = ring_idx;
            automatic int d1 = (ring_idx + 1) % 4;
            automatic int bz0 = n_busy;
            automatic int miss = 0;
            for (int k = 0; k < 4; k++) arm(k, 1'b1, 1'b1);
            arm(d1, 1'b0, 1'b1);
            for (int j = 0; j < 16; j++) mem[8'h40 + d1*16 + j] = 8'hEE;
            send(12, 8'h90);
            check(rd16(d0*8) == {3'b000 | 3'(d0 == 3), 1'b1, 1'b0, 1'b1, 10'd0},
                  "R9 R5 first buffer closed", rd16(d0*8),
                  {3'b000 | 3'(d0 == 3), 1'b1, 1'b0, 1'b1, 10'd0});
            check(rd16(d0*8+2) == 16'd8, "R4 first buffer length", rd16(d0*8+2), 8);
            check(n_busy - bz0 == 1, "R9 busy event", n_busy - bz0, 1);
            check(rd16(d1*8) == {3'b000 | 3'(d1 == 3), 1'b1, 12'd0},
                  "R9 busy descriptor untouched", rd16(d1*8),
                  {3'b000 | 3'(d1 == 3), 1'b1, 12'd0});
            for (int j = 0; j < 16; j++) if (mem[8'h40 + d1*16 + j] != 8'hEE) miss++;
            check(miss == 0, "R9 busy buffer untouched", miss, 0);
            arm(d1, 1'b1, 1'b1);
            send(2, 8'hA0);
            check(rd16(d1*8) == {3'b000 | 3'(d1 == 3), 1'b1, 1'b1, 1'b1, 10'd0},
                  "R9 refetch same descriptor", rd16(d1*8),
                  {3'b000 | 3'(d1 == 3), 1'b1, 1'b1, 1'b1, 10'd0});
            check(mem[8'h40 + d1*16 + 1] == 8'hA1, "R9 R3 refetch data",
                  mem[8'h40 + d1*16 + 1], 8'hA1);
            ring_idx = (ring_idx + 2) % 4;
        end

        // R9 busy at frame start
        begin
            automatic int d2 = ring_idx;
            automatic int bz0 = n_busy;
            for (int k = 0; k < 4; k++) arm(k, 1'b1, 1'b1);
            arm(d2, 1'b0, 1'b0);
            send(3, 8'h10);
            check(n_busy - bz0 == 1, "R9 busy at frame start", n_busy - bz0, 1);
            check(rd16(d2*8) == {3'b000 | 3'(d2 == 3), 13'd0}, "R9 start descriptor untouched",
                  rd16(d2*8), {3'b000 | 3'(d2 == 3), 13'd0});
        end

        // R10 one-entry ring
        begin
            automatic int cf0 = n_cfg;
            mem[8'h80] = 8'hA0; mem[8'h81] = 8'h00; mem[8'h82] = 8'h00; mem[8'h83] = 8'h00;
            mem[8'h84] = 8'h00; mem[8'h85] = 8'h00; mem[8'h86] = 8'h00; mem[8'h87] = 8'hC0;
            mem[8'hC0] = 8'h55;
            do_reset(32'h80);
            send(2, 8'h33);
            check(n_cfg - cf0 == 1, "R10 config event", n_cfg - cf0, 1);
            check(rd16(8'h80) == 16'hA000, "R10 descriptor untouched", rd16(8'h80), 16'hA000);
            check(mem[8'hC0] == 8'h55, "R10 buffer untouched", mem[8'hC0], 8'h55);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule